// File: doc/BRIEF.md
# Maskable Interrupt Status Unit

This unit collects the interrupt sources of a serial bus controller into one status word and drives a single interrupt line. Nine of the sources are short event pulses that the unit remembers until software clears them. The other two are live levels that follow the transmit and receive FIFO fill levels against programmable thresholds. A mask register selects which sources can raise the interrupt line. A masked status view is exposed next to the raw view.

Each remembered source has its own read-to-clear strobe. Software can therefore retire exactly the sources it has serviced, and an event that arrives between a status read and a clear is never lost. A global clear strobe retires every remembered source at once. When a transmit abort happens, the unit also stores a reason word. That word survives the global clear and is wiped only by the transmit-abort clear strobe. Generating the events and decoding the register bus are outside this unit: read accesses arrive as one-cycle strobes.

Top module: `irq_stat_unit`

## Requirements
- R1: After a synchronous reset, `raw_stat`, `masked_stat`, `abort_reason` and `irq` are zero, and `mask_q` is all ones (0x7FF).
- R2: A pulse on `evt_in[i]` (i in 0..8) sets `raw_stat[i]` one cycle later, and the bit stays set while no clear applies. Bit map: 0 transmit abort, 1 stop seen, 2 start seen, 3 RX underflow, 4 RX overflow, 5 TX overflow, 6 RX done, 7 activity, 8 general call.
- R3: A pulse on `clr_rd[i]` clears `raw_stat[i]` on the next cycle and leaves every other bit unchanged.
- R4: A pulse on `clr_all_rd` clears `raw_stat[8:0]` on the next cycle. It does not affect `raw_stat[10:9]` or `abort_reason`.
- R5: If a source's event and a clear of that source (per-source or global) occur in the same cycle, the event wins and the bit stays set.
- R6: `raw_stat[9]` (TX empty) is 1 one cycle after `tx_level <= tx_thresh` is sampled, and 0 otherwise.
- R7: `raw_stat[10]` (RX full) is 1 one cycle after `rx_level > rx_thresh` is sampled, and 0 otherwise.
- R8: `masked_stat` always equals `raw_stat & mask_q`.
- R9: `irq` is 1 exactly when `ctl_enable` was 1 at the updating edge and `masked_stat` is non-zero. It is aligned with `raw_stat`.
- R10: An event on bit 0 loads `abort_reason_in` into `abort_reason`. `clr_rd[0]` zeroes it. If an abort event and its clear occur in the same cycle, the new reason is kept. Otherwise the value holds.
- R11: `mask_wr` loads `mask_wdata` into `mask_q`. The new mask is reflected in `masked_stat` and `irq` in the same cycle that `mask_q` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_enable | input | 1 | Controller enabled; gates the interrupt line |
| evt_in | input | 9 | Event pulses of the remembered sources |
| abort_reason_in | input | 16 | Reason word that accompanies a transmit abort |
| tx_level | input | 5 | Transmit FIFO fill level |
| tx_thresh | input | 5 | Transmit threshold |
| rx_level | input | 5 | Receive FIFO fill level |
| rx_thresh | input | 5 | Receive threshold |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 11 | Mask write data |
| clr_rd | input | 9 | Per-source read-to-clear strobes |
| clr_all_rd | input | 1 | Global read-to-clear strobe |
| raw_stat | output | 11 | Raw status |
| masked_stat | output | 11 | Raw status ANDed with the mask |
| mask_q | output | 11 | Current mask |
| abort_reason | output | 16 | Stored transmit-abort reason |
| irq | output | 1 | Combined interrupt |

## Verification
Every result of this unit is due exactly one clock edge after the stimulus that causes it. This holds for event latching, clears, level compares, mask writes, the reason word and the interrupt line alike, since all of them are computed from next-state values and registered together. The bench drives each stimulus on a falling edge, lets one rising edge pass, and compares all outputs at the following falling edge. A result is therefore never read before the register that holds it has been updated.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int N_LATCH   = 9;
  localparam int N_SRC     = N_LATCH + 2;
  localparam int B_ABORT   = 0;
  localparam int B_TXEMPTY = N_LATCH;
  localparam int B_RXFULL  = N_LATCH + 1;
endpackage

// File: rtl/isr_evt_latch.sv
module isr_evt_latch #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ev,
  input  logic [W-1:0] clr,
  input  logic         clr_all,
  output logic [W-1:0] nxt,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    // a fresh event dominates any clear in the same cycle
    assign nxt[i] = ev[i] | (q[i] & ~clr[i] & ~clr_all);

    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= nxt[i];
    end

    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (rst)
      ev[i] |=> q[i]);
    assert_own_clear_R3: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !ev[i]) |=> !q[i]);
    assert_global_clear_R4: assert property (@(posedge clk) disable iff (rst)
      (clr_all && !ev[i]) |=> !q[i]);
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (q[i] && !clr[i] && !clr_all) |=> q[i]);
  end
endmodule

// File: rtl/isr_level_cmp.sv
module isr_level_cmp #(
  parameter int LW = 5
) (
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] tx_thresh,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] rx_thresh,
  output logic          tx_empty,
  output logic          rx_full
);
  always_comb begin
    tx_empty = (tx_level <= tx_thresh);
    rx_full  = (rx_level >  rx_thresh);
  end
endmodule

// File: rtl/isr_abort_cap.sv
module isr_abort_cap #(
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort_ev,
  input  logic [RW-1:0] reason_in,
  input  logic          abort_clr,
  output logic [RW-1:0] reason_q
);
  always_ff @(posedge clk) begin
    if (rst)           reason_q <= '0;
    else if (abort_ev) reason_q <= reason_in;
    else if (abort_clr) reason_q <= '0;
  end

  assert_reason_load_R10: assert property (@(posedge clk) disable iff (rst)
    abort_ev |=> (reason_q == $past(reason_in)));
  assert_reason_wipe_R10: assert property (@(posedge clk) disable iff (rst)
    (abort_clr && !abort_ev) |=> (reason_q == '0));
  assert_reason_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!abort_clr && !abort_ev) |=> $stable(reason_q));
endmodule

// File: rtl/irq_stat_unit.sv
module irq_stat_unit
  import irq_stat_pkg::*;
#(
  parameter int LW = 5,
  parameter int RW = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_enable,
  input  logic [N_LATCH-1:0] evt_in,
  input  logic [RW-1:0]      abort_reason_in,
  input  logic [LW-1:0]      tx_level,
  input  logic [LW-1:0]      tx_thresh,
  input  logic [LW-1:0]      rx_level,
  input  logic [LW-1:0]      rx_thresh,
  input  logic               mask_wr,
  input  logic [N_SRC-1:0]   mask_wdata,
  input  logic [N_LATCH-1:0] clr_rd,
  input  logic               clr_all_rd,
  output logic [N_SRC-1:0]   raw_stat,
  output logic [N_SRC-1:0]   masked_stat,
  output logic [N_SRC-1:0]   mask_q,
  output logic [RW-1:0]      abort_reason,
  output logic               irq
);
  logic [N_LATCH-1:0] lat_nxt, lat_q;
  logic               tx_empty_c, rx_full_c;
  logic [1:0]         lvl_q;
  logic [N_SRC-1:0]   mask_nxt, raw_nxt, masked_nxt;

  isr_evt_latch #(.W(N_LATCH)) u_latch (
    .clk(clk), .rst(rst), .ev(evt_in), .clr(clr_rd),
    .clr_all(clr_all_rd), .nxt(lat_nxt), .q(lat_q)
  );

  isr_level_cmp #(.LW(LW)) u_level (
    .tx_level(tx_level), .tx_thresh(tx_thresh),
    .rx_level(rx_level), .rx_thresh(rx_thresh),
    .tx_empty(tx_empty_c), .rx_full(rx_full_c)
  );

  isr_abort_cap #(.RW(RW)) u_abort (
    .clk(clk), .rst(rst), .abort_ev(evt_in[B_ABORT]),
    .reason_in(abort_reason_in), .abort_clr(clr_rd[B_ABORT]),
    .reason_q(abort_reason)
  );

  always_comb begin
    mask_nxt   = mask_wr ? mask_wdata : mask_q;
    raw_nxt    = {rx_full_c, tx_empty_c, lat_nxt};
    masked_nxt = raw_nxt & mask_nxt;
  end

  // mask, masked view and irq are registered from next-state values so
  // that every output moves on the same edge as the raw status
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q      <= '1;
      lvl_q       <= '0;
      masked_stat <= '0;
      irq         <= 1'b0;
    end else begin
      mask_q      <= mask_nxt;
      lvl_q       <= {rx_full_c, tx_empty_c};
      masked_stat <= masked_nxt;
      irq         <= ctl_enable & (|masked_nxt);
    end
  end

  assign raw_stat = {lvl_q, lat_q};

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (raw_stat == '0 && mask_q == '1 && abort_reason == '0 && !irq));
  assert_masked_view_R8: assert property (@(posedge clk) disable iff (rst)
    masked_stat == (raw_stat & mask_q));
  assert_irq_needs_src_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> (masked_stat != '0));
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ctl_enable)) |-> !irq);
  assert_tx_empty_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (raw_stat[B_TXEMPTY] == $past(tx_level <= tx_thresh)));
  assert_rx_full_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (raw_stat[B_RXFULL] == $past(rx_level > rx_thresh)));
  assert_mask_load_R11: assert property (@(posedge clk) disable iff (rst)
    mask_wr |=> (mask_q == $past(mask_wdata)));
endmodule

// File: tb/irq_stat_unit_bench.sv
module irq_stat_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_enable;
  logic [8:0]  evt_in;
  logic [15:0] abort_reason_in;
  logic [4:0]  tx_level, tx_thresh, rx_level, rx_thresh;
  logic        mask_wr;
  logic [10:0] mask_wdata;
  logic [8:0]  clr_rd;
  logic        clr_all_rd;
  logic [10:0] raw_stat, masked_stat, mask_q;
  logic [15:0] abort_reason;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_stat_unit u_irq_stat_unit (
    .clk(clk), .rst(rst), .ctl_enable(ctl_enable), .evt_in(evt_in),
    .abort_reason_in(abort_reason_in), .tx_level(tx_level), .tx_thresh(tx_thresh),
    .rx_level(rx_level), .rx_thresh(rx_thresh), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .clr_rd(clr_rd), .clr_all_rd(clr_all_rd),
    .raw_stat(raw_stat), .masked_stat(masked_stat), .mask_q(mask_q),
    .abort_reason(abort_reason), .irq(irq)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [8:0]  ev;
    logic [8:0]  clr;
    logic        clr_all;
    logic [4:0]  txl;
    logic [4:0]  rxl;
    logic        mw;
    logic [10:0] md;
    logic        en;
    logic [10:0] eraw;
    logic [10:0] emsk;
    logic        eirq;
  } vec_t;

  // tx_thresh = 4, rx_thresh = 2 throughout; idle tx_level = 8
  localparam vec_t TBL [14] = '{
    '{4'd2,  9'h002, 9'h000, 1'b0, 5'd8, 5'd0, 1'b0, 11'h000, 1'b1, 11'h002, 11'h002, 1'b1}, // R2
    '{4'd2,  9'h088, 9'h000, 1'b0, 5'd8, 5'd0, 1'b0, 11'h000, 1'b1, 11'h08A, 11'h08A, 1'b1}, // R2
    '{4'd3,  9'h000, 9'h008, 1'b0, 5'd8, 5'd0, 1'b0, 11'h000, 1'b1, 11'h082, 11'h082, 1'b1}, // R3
    '{4'd5,  9'h002, 9'h002, 1'b0, 5'd8, 5'd0, 1'b0, 11'h000, 1'b1, 11'h082, 11'h082, 1'b1}, // R5
    '{4'd11, 9'h000, 9'h000, 1'b0, 5'd8, 5'd0, 1'b1, 11'h002, 1'b1, 11'h082, 11'h002, 1'b1}, // R11
    '{4'd8,  9'h000, 9'h002, 1'b0, 5'd8, 5'd0, 1'b0, 11'h000, 1'b1, 11'h080, 11'h000, 1'b0}, // R8
    '{4'd6,  9'h000, 9'h000, 1'b0, 5'd4, 5'd0, 1'b0, 11'h000, 1'b1, 11'h280, 11'h000, 1'b0}, // R6
    '{4'd11, 9'h000, 9'h000, 1'b0, 5'd4, 5'd0, 1'b1, 11'h7FF, 1'b1, 11'h280, 11'h280, 1'b1}, // R11
    '{4'd9,  9'h000, 9'h000, 1'b0, 5'd4, 5'd0, 1'b0, 11'h000, 1'b0, 11'h280, 11'h280, 1'b0}, // R9
    '{4'd7,  9'h000, 9'h000, 1'b0, 5'd5, 5'd3, 1'b0, 11'h000, 1'b1, 11'h480, 11'h480, 1'b1}, // R7
    '{4'd7,  9'h000, 9'h000, 1'b0, 5'd5, 5'd2, 1'b0, 11'h000, 1'b1, 11'h080, 11'h080, 1'b1}, // R7
    '{4'd5,  9'h100, 9'h000, 1'b1, 5'd3, 5'd0, 1'b0, 11'h000, 1'b1, 11'h300, 11'h300, 1'b1}, // R5
    '{4'd4,  9'h000, 9'h000, 1'b1, 5'd3, 5'd0, 1'b0, 11'h000, 1'b1, 11'h200, 11'h200, 1'b1}, // R4
    '{4'd4,  9'h000, 9'h000, 1'b0, 5'd8, 5'd0, 1'b0, 11'h000, 1'b1, 11'h000, 11'h000, 1'b0}  // R4
  };

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic idle();
    ctl_enable = 1'b1; evt_in = '0; abort_reason_in = '0;
    tx_level = 5'd8; tx_thresh = 5'd4; rx_level = 5'd0; rx_thresh = 5'd2;
    mask_wr = 1'b0; mask_wdata = '0; clr_rd = '0; clr_all_rd = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_reset();
    chk("R1", "raw", 32'(raw_stat), 32'h0);
    chk("R1", "masked", 32'(masked_stat), 32'h0);
    chk("R1", "mask", 32'(mask_q), 32'h7FF);
    chk("R1", "reason", 32'(abort_reason), 32'h0);
    chk("R1", "irq", 32'(irq), 32'h0);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk_reset();

    for (int k = 0; k < 14; k++) begin
      idle();
      evt_in = TBL[k].ev; clr_rd = TBL[k].clr; clr_all_rd = TBL[k].clr_all;
      tx_level = TBL[k].txl; rx_level = TBL[k].rxl; mask_wr = TBL[k].mw;
      mask_wdata = TBL[k].md; ctl_enable = TBL[k].en;
      tick();
      chk($sformatf("R%0d", TBL[k].req), $sformatf("vec %0d raw", k), 32'(raw_stat), 32'(TBL[k].eraw));
      chk("R8", $sformatf("vec %0d masked", k), 32'(masked_stat), 32'(TBL[k].emsk));
      chk("R9", $sformatf("vec %0d irq", k), 32'(irq), 32'(TBL[k].eirq));
    end

    // R10: abort event captures the reason word
    idle(); evt_in = 9'h001; abort_reason_in = 16'hBEEF; tick();
    chk("R10", "reason load", 32'(abort_reason), 32'hBEEF);
    chk("R2", "abort bit", 32'(raw_stat[0]), 32'h1);
    // R4: global clear drops the bit but keeps the reason
    idle(); clr_all_rd = 1'b1; tick();
    chk("R4", "abort bit after global clear", 32'(raw_stat[0]), 32'h0);
    chk("R4", "reason after global clear", 32'(abort_reason), 32'hBEEF);
    // R10: other clears keep the reason, it holds over idle cycles
    idle(); clr_rd = 9'h1FE; tick(); tick();
    chk("R10", "reason hold", 32'(abort_reason), 32'hBEEF);
    // R10: the abort clear zeroes it
    idle(); clr_rd = 9'h001; tick();
    chk("R10", "reason wipe", 32'(abort_reason), 32'h0);
    // R10 / R5: new abort in the same cycle as its clear wins
    idle(); evt_in = 9'h001; clr_rd = 9'h001; abort_reason_in = 16'h1234; tick();
    chk("R10", "reason race", 32'(abort_reason), 32'h1234);
    chk("R5", "abort bit race", 32'(raw_stat[0]), 32'h1);
    // R6 boundary: level just above threshold is not empty
    idle(); tx_level = 5'd5; tick();
    chk("R6", "tx above thresh", 32'(raw_stat[9]), 32'h0);
    idle(); tx_level = 5'd0; tick();
    chk("R6", "tx zero", 32'(raw_stat[9]), 32'h1);

    // R1: reset in the middle of activity
    idle(); mask_wr = 1'b1; mask_wdata = 11'h00F; evt_in = 9'h1F0; tick();
    rst = 1'b1; idle(); tick();
    rst = 1'b0;
    chk_reset();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule